// File: doc/BRIEF.md
# Seconds Prescaler and Calendar Counter

The block divides a 32.768 kHz timebase down to one tick per second and keeps a binary calendar of second, minute, hour, day, month and two-digit year (years 2000 to 2099). Month lengths and leap years are handled. The live calendar fields and a one-cycle seconds pulse go to downstream alarm and timestamp logic.

A host sets the time by raising a hold input. Hold freezes the calendar and clears the prescaler. The host then writes fields one at a time through a field select and data bus, and drops hold. Out-of-range values are clamped to the nearest legal value. For reads, the host pulses a snapshot strobe. A shadow copy of every field is captured at that edge and held until the next strobe, so a multi-field read never mixes values from both sides of a second boundary. A tick-enable input lets an external trim circuit remove timebase cycles.

Top module: `rtc_calendar`

## Requirements
- R1: With tick enable high and hold low, `secTick` is high for exactly one cycle after every DIV clock edges. The calendar is one second later in the same cycle that `secTick` is high.
- R2: A clock edge with `tickEn` low does not advance the prescaler. A second therefore takes DIV enabled edges.
- R3: Carries cascade as follows. Second 59 goes to 0 and increments the minute. Minute 59 goes to 0 and increments the hour. Hour 23 goes to 0 and increments the day.
- R4: The last day of a month is 30 for months 4, 6, 9 and 11. It is 31 for the other months except month 2. Month 2 ends on day 29 when the year is divisible by 4 and on day 28 otherwise. After the last day the day goes to 1 and the month increments. After month 12 the month goes to 1 and the year increments.
- R5: Year 99, month 12, day 31, 23:59:59 rolls over to year 0, month 1, day 1, 00:00:00.
- R6: While `holdReq` is high the calendar does not advance, no `secTick` occurs and the prescaler is cleared. After hold drops, the first `secTick` follows DIV enabled edges.
- R7: A write takes effect at an edge with both `wrEn` and `holdReq` high. `wrSel` selects the field: 0 second, 1 minute, 2 hour, 3 day, 4 month, 5 year. Select values 6 and 7 have no effect, and a write with hold low has no effect.
- R8: A written value is clamped into its legal range. Second is limited to 0..59, minute to 0..59, hour to 0..23 and year to 0..99. Month is limited to 1..12. Day is limited to 1..(last day of the current month and year). A write to month or year also lowers the stored day to the last day of the resulting month when the day exceeds it.
- R9: At an edge with `snapReq` high, the snapshot outputs take the calendar value from just before that edge, even when a tick or a write happens at the same edge. They keep that value until the next strobe.
- R10: Outside hold, each advance yields a time strictly later than the previous one. The only exception is the R5 wrap.
- R11: After reset the calendar and the snapshot both read year 0, month 1, day 1, 00:00:00, and `secTick` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (32.768 kHz) |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Prescaler count enable for trimming |
| holdReq | input | 1 | Freeze calendar and clear prescaler; enables writes |
| wrEn | input | 1 | Field write strobe |
| wrSel | input | 3 | Field select for writes |
| wrData | input | 8 | Binary value to write |
| snapReq | input | 1 | Capture calendar into the snapshot outputs |
| secTick | output | 1 | One-cycle pulse when a second elapses |
| timeSec | output | 6 | Live second |
| timeMin | output | 6 | Live minute |
| timeHour | output | 5 | Live hour |
| timeDay | output | 5 | Live day of month |
| timeMonth | output | 4 | Live month |
| timeYear | output | 7 | Live year offset from 2000 |
| snapSec | output | 6 | Snapshot second |
| snapMin | output | 6 | Snapshot minute |
| snapHour | output | 5 | Snapshot hour |
| snapDay | output | 5 | Snapshot day |
| snapMonth | output | 4 | Snapshot month |
| snapYear | output | 7 | Snapshot year |

## Verification
Free-running ticks and a tick enable that toggles every cycle separate a correct prescaler period from one that ignores the enable. Times set just before a minute, hour, 30-day month end, non-leap and leap February end and the century wrap tell each carry path apart. Out-of-range writes, and month or year writes that shrink the current month, exercise the clamping rules. Writes outside hold and to unused selects show that the calendar ignores them. Snapshot strobes placed both between ticks and on a tick edge show that the shadow always holds one whole pre-edge time.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] month;
    logic [4:0] day;
    logic [4:0] hour;
    logic [5:0] minute;
    logic [5:0] second;
  } calTime_t;

  typedef struct packed {
    logic advance;
    logic write;
    logic snap;
  } calStrobe_t;

  typedef enum logic [SEL_W-1:0] {
    FS_SEC   = 3'd0,
    FS_MIN   = 3'd1,
    FS_HOUR  = 3'd2,
    FS_DAY   = 3'd3,
    FS_MONTH = 3'd4,
    FS_YEAR  = 3'd5
  } fieldSel_e;

  localparam calTime_t CAL_RESET = '{year: 7'd0, month: 4'd1, day: 5'd1,
                                     hour: 5'd0, minute: 6'd0, second: 6'd0};

  function automatic logic [4:0] monthDays(logic [3:0] m, logic [6:0] y);
    logic [4:0] d;
    case (m)
      4'd2: d = (y[1:0] == 2'd0) ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
      default: d = 5'd31;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       holdReq,
  input  logic       wrEn,
  input  logic       snapReq,
  output calStrobe_t stb,
  output logic       secTick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] preCnt;

  always_comb begin
    stb.advance = !holdReq && tickEn && (preCnt == LAST);
    stb.write   = holdReq && wrEn;
    stb.snap    = snapReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      secTick <= 1'b0;
    end else begin
      secTick <= stb.advance;
      if (holdReq)
        preCnt <= '0;
      else if (tickEn)
        preCnt <= (preCnt == LAST) ? '0 : preCnt + 1'b1;
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    holdReq |=> !secTick); // R6
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick); // R1
  AST_PAUSE_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> !secTick); // R2
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        stb,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  output calTime_t          cur,
  output calTime_t          shadow
);
  calTime_t nxt;

  function automatic logic [DATA_W-1:0] clampTo(logic [DATA_W-1:0] v,
                                                logic [DATA_W-1:0] lo,
                                                logic [DATA_W-1:0] hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic calTime_t incTime(calTime_t t);
    calTime_t r;
    r = t;
    if (t.second != 6'd59) r.second = t.second + 6'd1;
    else begin
      r.second = 6'd0;
      if (t.minute != 6'd59) r.minute = t.minute + 6'd1;
      else begin
        r.minute = 6'd0;
        if (t.hour != 5'd23) r.hour = t.hour + 5'd1;
        else begin
          r.hour = 5'd0;
          if (t.day != monthDays(t.month, t.year)) r.day = t.day + 5'd1;
          else begin
            r.day = 5'd1;
            if (t.month != 4'd12) r.month = t.month + 4'd1;
            else begin
              r.month = 4'd1;
              r.year  = (t.year == 7'd99) ? 7'd0 : t.year + 7'd1;
            end
          end
        end
      end
    end
    return r;
  endfunction

  always_comb begin
    logic [3:0] newMonth;
    logic [6:0] newYear;
    logic [4:0] lastDay;
    nxt      = cur;
    newMonth = cur.month;
    newYear  = cur.year;
    lastDay  = monthDays(cur.month, cur.year);
    if (stb.advance) begin
      nxt = incTime(cur);
    end else if (stb.write) begin
      case (fieldSel_e'(wrSel))
        FS_SEC:  nxt.second = 6'(clampTo(wrData, 8'd0, 8'd59));
        FS_MIN:  nxt.minute = 6'(clampTo(wrData, 8'd0, 8'd59));
        FS_HOUR: nxt.hour   = 5'(clampTo(wrData, 8'd0, 8'd23));
        FS_DAY:  nxt.day    = 5'(clampTo(wrData, 8'd1, 8'(lastDay)));
        FS_MONTH: begin
          newMonth  = 4'(clampTo(wrData, 8'd1, 8'd12));
          lastDay   = monthDays(newMonth, cur.year);
          nxt.month = newMonth;
          if (cur.day > lastDay) nxt.day = lastDay;
        end
        FS_YEAR: begin
          newYear  = 7'(clampTo(wrData, 8'd0, 8'd99));
          lastDay  = monthDays(cur.month, newYear);
          nxt.year = newYear;
          if (cur.day > lastDay) nxt.day = lastDay;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cur    <= CAL_RESET;
      shadow <= CAL_RESET;
    end else begin
      cur <= nxt;
      if (stb.snap) shadow <= cur;
    end
  end

  AST_FIELD_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (cur.second < 6'd60) && (cur.minute < 6'd60) && (cur.hour < 5'd24) &&
    (cur.month >= 4'd1) && (cur.month <= 4'd12) && (cur.year <= 7'd99) &&
    (cur.day >= 5'd1) && (cur.day <= monthDays(cur.month, cur.year))); // R8
  AST_SHADOW_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.snap |=> $stable(shadow)); // R9
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.write) |=> $stable(cur)); // R7
  AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |=> ((cur > $past(cur)) || (cur == CAL_RESET))); // R10
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int DIV = 32768
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       holdReq,
  input  logic       wrEn,
  input  logic [2:0] wrSel,
  input  logic [7:0] wrData,
  input  logic       snapReq,
  output logic       secTick,
  output logic [5:0] timeSec,
  output logic [5:0] timeMin,
  output logic [4:0] timeHour,
  output logic [4:0] timeDay,
  output logic [3:0] timeMonth,
  output logic [6:0] timeYear,
  output logic [5:0] snapSec,
  output logic [5:0] snapMin,
  output logic [4:0] snapHour,
  output logic [4:0] snapDay,
  output logic [3:0] snapMonth,
  output logic [6:0] snapYear
);
  calStrobe_t stb;
  calTime_t   cur;
  calTime_t   shadow;

  rtc_ctrl #(.DIV(DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .holdReq(holdReq),
    .wrEn(wrEn), .snapReq(snapReq), .stb(stb), .secTick(secTick)
  );

  rtc_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrSel(wrSel), .wrData(wrData),
    .cur(cur), .shadow(shadow)
  );

  assign timeSec   = cur.second;
  assign timeMin   = cur.minute;
  assign timeHour  = cur.hour;
  assign timeDay   = cur.day;
  assign timeMonth = cur.month;
  assign timeYear  = cur.year;
  assign snapSec   = shadow.second;
  assign snapMin   = shadow.minute;
  assign snapHour  = shadow.hour;
  assign snapDay   = shadow.day;
  assign snapMonth = shadow.month;
  assign snapYear  = shadow.year;
endmodule

// File: tb/tb_rtc_calendar.sv
module tb_rtc_calendar;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b1, holdReq = 1'b0, wrEn = 1'b0, snapReq = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic secTick;
  logic [5:0] timeSec, timeMin, snapSec, snapMin;
  logic [4:0] timeHour, timeDay, snapHour, snapDay;
  logic [3:0] timeMonth, snapMonth;
  logic [6:0] timeYear, snapYear;

  int nChecks = 0, nFail = 0;
  bit finished = 0;
  string curReq = "R11";

  rtc_calendar #(.DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .holdReq(holdReq), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .snapReq(snapReq), .secTick(secTick),
    .timeSec(timeSec), .timeMin(timeMin), .timeHour(timeHour), .timeDay(timeDay),
    .timeMonth(timeMonth), .timeYear(timeYear), .snapSec(snapSec), .snapMin(snapMin),
    .snapHour(snapHour), .snapDay(snapDay), .snapMonth(snapMonth), .snapYear(snapYear)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [32:0] packT(int y, int mo, int d, int h, int mi, int s);
    return {7'(y), 4'(mo), 5'(d), 5'(h), 6'(mi), 6'(s)};
  endfunction
  function automatic int mdays(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic int clampI(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  wire [32:0] dutTime = {timeYear, timeMonth, timeDay, timeHour, timeMin, timeSec};
  wire [32:0] dutSnap = {snapYear, snapMonth, snapDay, snapHour, snapMin, snapSec};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mY = 0, mMo = 1, mD = 1, mH = 0, mMi = 0, mS = 0;
  int sY = 0, sMo = 1, sD = 1, sH = 0, sMi = 0, sS = 0;
  int mCnt = 0;
  bit mTick = 0, mValid = 0;

  always @(posedge clk) begin
    mValid <= 1'b1;
    if (!rstN) begin
      mY = 0; mMo = 1; mD = 1; mH = 0; mMi = 0; mS = 0;
      sY = 0; sMo = 1; sD = 1; sH = 0; sMi = 0; sS = 0;
      mCnt = 0; mTick = 0;
    end else begin
      if (snapReq) begin
        sY = mY; sMo = mMo; sD = mD; sH = mH; sMi = mMi; sS = mS;
      end
      mTick = 0;
      if (holdReq) begin
        mCnt = 0;
        if (wrEn) begin
          case (wrSel)
            3'd0: mS  = clampI(wrData, 0, 59);
            3'd1: mMi = clampI(wrData, 0, 59);
            3'd2: mH  = clampI(wrData, 0, 23);
            3'd3: mD  = clampI(wrData, 1, mdays(mMo, mY));
            3'd4: begin mMo = clampI(wrData, 1, 12); if (mD > mdays(mMo, mY)) mD = mdays(mMo, mY); end
            3'd5: begin mY = clampI(wrData, 0, 99); if (mD > mdays(mMo, mY)) mD = mdays(mMo, mY); end
            default: ;
          endcase
        end
      end else if (tickEn) begin
        if (mCnt == DIV - 1) begin
          mCnt = 0; mTick = 1;
          mS++;
          if (mS == 60) begin mS = 0; mMi++; end
          if (mMi == 60) begin mMi = 0; mH++; end
          if (mH == 24) begin mH = 0; mD++; end
          if (mD > mdays(mMo, mY)) begin mD = 1; mMo++; end
          if (mMo == 13) begin mMo = 1; mY++; end
          if (mY == 100) mY = 0;
        end else mCnt++;
      end
    end
  end

  logic [32:0] prevTime = '0;
  always @(negedge clk) begin
    if (mValid && !finished) begin
      chk(curReq, dutTime, packT(mY, mMo, mD, mH, mMi, mS));
      chk({curReq, "/R9"}, dutSnap, packT(sY, sMo, sD, sH, sMi, sS));
      chk({curReq, "/R1"}, secTick, mTick);
      if (rstN && secTick && !(dutTime > prevTime) && dutTime != packT(0, 1, 1, 0, 0, 0))
        chk("R10", dutTime, prevTime + 1);
      prevTime = dutTime;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wrField(int sel, int v);
    wrEn = 1; wrSel = 3'(sel); wrData = 8'(v); step(); wrEn = 0;
  endtask
  task automatic setTime(int y, int mo, int d, int h, int mi, int s);
    holdReq = 1; step();
    wrField(5, y); wrField(4, mo); wrField(3, d);
    wrField(2, h); wrField(1, mi); wrField(0, s);
    holdReq = 0;
  endtask
  task automatic waitTicks(int n);
    int seen = 0;
    while (seen < n) begin step(); if (secTick) seen++; end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11", dutTime, packT(0, 1, 1, 0, 0, 0));
    chk("R11", dutSnap, packT(0, 1, 1, 0, 0, 0));
    chk("R11", secTick, 0);
    @(posedge clk); #1; rstN = 1;

    curReq = "R1"; n = 0;
    for (int i = 0; i < 40; i++) begin step(); if (secTick) n++; end
    chk("R1", n, 10);
    chk("R1", timeSec, 10);

    curReq = "R2"; n = 0;
    for (int i = 0; i < 40; i++) begin tickEn = (i % 2 == 0); step(); if (secTick) n++; end
    tickEn = 1;
    chk("R2", n, 5);
    chk("R2", timeSec, 15);

    curReq = "R3";
    setTime(23, 6, 15, 10, 59, 59); waitTicks(1);
    chk("R3", dutTime, packT(23, 6, 15, 11, 0, 0));
    setTime(23, 6, 30, 23, 59, 59); waitTicks(1);
    chk("R3", dutTime, packT(23, 7, 1, 0, 0, 0));

    curReq = "R4";
    setTime(23, 2, 28, 23, 59, 58); waitTicks(2);
    chk("R4", dutTime, packT(23, 3, 1, 0, 0, 0));
    setTime(24, 2, 28, 23, 59, 59); waitTicks(1);
    chk("R4", dutTime, packT(24, 2, 29, 0, 0, 0));
    setTime(24, 2, 29, 23, 59, 59); waitTicks(1);
    chk("R4", dutTime, packT(24, 3, 1, 0, 0, 0));
    setTime(23, 12, 31, 23, 59, 59); waitTicks(1);
    chk("R4", dutTime, packT(24, 1, 1, 0, 0, 0));

    curReq = "R5";
    setTime(99, 12, 31, 23, 59, 59); waitTicks(1);
    chk("R5", dutTime, packT(0, 1, 1, 0, 0, 0));

    curReq = "R8";
    holdReq = 1; step();
    wrField(4, 4); wrField(3, 31);
    chk("R8", timeDay, 30);
    wrField(4, 13); chk("R8", timeMonth, 12);
    wrField(0, 75); chk("R8", timeSec, 59);
    wrField(1, 200); chk("R8", timeMin, 59);
    wrField(2, 30); chk("R8", timeHour, 23);
    wrField(3, 0); chk("R8", timeDay, 1);
    wrField(5, 150); chk("R8", timeYear, 99);
    wrField(4, 1); wrField(3, 31); wrField(4, 2);
    chk("R8", timeDay, 28);
    wrField(5, 96); wrField(3, 29); wrField(5, 97);
    chk("R8", timeDay, 28);

    curReq = "R7";
    wrField(6, 5); wrField(7, 5);
    chk("R7", dutTime, packT(97, 2, 28, 23, 59, 59));
    holdReq = 0; tickEn = 0;
    wrField(0, 30); wrField(5, 10);
    chk("R7", dutTime, packT(97, 2, 28, 23, 59, 59));
    tickEn = 1;

    curReq = "R6";
    holdReq = 1; n = 0;
    for (int i = 0; i < 20; i++) begin step(); if (secTick) n++; end
    chk("R6", n, 0);
    chk("R6", dutTime, packT(97, 2, 28, 23, 59, 59));
    holdReq = 0; n = 0;
    for (int i = 0; i < 3 * DIV; i++) begin step(); n++; if (secTick) break; end
    chk("R6", n, DIV);
    chk("R6", dutTime, packT(97, 3, 1, 0, 0, 0));

    curReq = "R9";
    setTime(50, 5, 5, 5, 5, 5);
    snapReq = 1; step(); snapReq = 0;
    chk("R9", dutSnap, packT(50, 5, 5, 5, 5, 5));
    waitTicks(12);
    chk("R9", dutSnap, packT(50, 5, 5, 5, 5, 5));
    setTime(50, 5, 5, 5, 59, 59);
    for (int i = 0; i < DIV - 1; i++) step();
    snapReq = 1; step(); snapReq = 0;
    chk("R9", secTick, 1);
    chk("R9", dutSnap, packT(50, 5, 5, 5, 59, 59));
    chk("R9", dutTime, packT(50, 5, 5, 6, 0, 0));

    curReq = "R10";
    setTime(31, 12, 31, 23, 59, 50);
    waitTicks(20);
    chk("R10", dutTime, packT(32, 1, 1, 0, 0, 10));

    step();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule